// File: doc/BRIEF.md
# Line Pixel Unpacker

This block sits in the pixel clock domain behind a memory read FIFO. It takes wide memory words from the FIFO read port and cuts each word into fixed-width pixels. It then presents one video line of pixels at a time. The same pixel stream drives two outputs: a plain valid/data pair and an AXI4-Stream master carrying side-band flags for frame start and frame end.

A line is armed by a line enable that the request logic holds high while the memory read is in flight. When the enable drops, the block emits exactly the programmed number of pixels and then goes idle. A frame-end pulse marks the line during which it arrives. That line's last pixel closes the frame, and the first pixel of the following line opens the next one. The FIFO is first-word-fall-through: the head word is visible whenever the FIFO is not empty, and a pop consumes it at the next clock.

Top module: `line_pixel_unpacker`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `pix_valid`, `m_tvalid`, `m_tlast`, `m_tuser`, `m_tkeep`, `m_tstrb` and `fifo_pop` are all zero.
- R2: A clock edge that samples `line_en` low, when the previous edge sampled it high, starts a line if the block is idle and `hres` is non-zero. The first pixel can appear on the outputs one clock after that edge.
- R3: Each started line produces exactly `hres` cycles with `pix_valid` high. An `hres` of zero starts no line.
- R4: Pixels leave each word least significant first. Pixel k of a word is bits [k*PIX_W +: PIX_W], so a 128-bit word holds 16 pixels of 8 bits.
- R5: `fifo_pop` is high in the cycle that emits the last pixel of a word, and also in the cycle that emits the last pixel of a line. The rest of a partly used word is discarded, so every line starts at pixel 0 of a fresh word.
- R6: While the FIFO is empty during a line, no pixel is emitted, `fifo_pop` stays low and the line's pixel count does not advance.
- R7: A falling edge of `line_en` while a line is still running has no effect: the running line still ends after `hres` pixels and no extra line follows.
- R8: `m_tuser[0]` (frame start) is high with the first pixel of the first line after reset. It is also high with the first pixel of the first line after a line that carried the frame-end flag, and it is low elsewhere.
- R9: A line carries the frame-end flag in either case below. `m_tuser[3]` and `m_tlast` are both high with its last pixel and low elsewhere. `m_tuser[2:1]` is always zero.
  - `frame_end` is high at any clock edge during the line, including the edge of the last pixel.
  - `frame_end` arrived while idle and this is the next line emitted.
- R10: `m_tvalid`/`m_tdata` equal `pix_valid`/`pix_data`. `m_tkeep` and `m_tstrb` (PIX_W/8 bits each) are all ones when `m_tvalid` is high and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_en | input | 1 | Line enable; its falling edge launches a line |
| frame_end | input | 1 | Frame end marker |
| hres | input | CNT_W | Pixels per line |
| fifo_rdata | input | WORD_W | Head word of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Consume the head word at the next clock |
| pix_valid | output | 1 | Native pixel valid |
| pix_data | output | PIX_W | Native pixel data |
| m_tvalid | output | 1 | Stream valid |
| m_tdata | output | PIX_W | Stream data |
| m_tkeep | output | PIX_W/8 | Stream keep bits |
| m_tstrb | output | PIX_W/8 | Stream strobe bits |
| m_tuser | output | 4 | Bit 0 frame start, bit 3 frame end |
| m_tlast | output | 1 | Last pixel of the frame |

## Verification
Two events can coincide: a frame-end pulse arriving on exactly the clock edge that emits the last pixel of a line, and the last pixel of a word coinciding with the last pixel of the line. The bench watches its own model's pixel count and raises `frame_end` for the single cycle in which that count reaches `hres-1`. It then expects `m_tlast` and `m_tuser[3]` on that pixel, and frame start on the next line. A one-pixel line with `frame_end` held high puts frame start and frame end on the same beat. A falling edge is also injected mid-line, and the per-line valid count must still equal `hres`.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

  localparam int USER_W = 4;

  // number of pixel lanes in one memory word
  function automatic int lanes_per_word(input int word_w, input int pix_w);
    return word_w / pix_w;
  endfunction

  // stream user field: bit 0 frame start, bit 3 frame end
  function automatic logic [USER_W-1:0] pack_user(input logic start_flag, input logic end_flag);
    return {end_flag, 2'b00, start_flag};
  endfunction

endpackage

// File: rtl/line_seq.sv
module line_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic [CNT_W-1:0] hres,
  input  logic             fifo_empty,
  output logic             active,
  output logic             adv,
  output logic             first_pix,
  output logic             last_pix
);

  logic             en_q;
  logic [CNT_W-1:0] cnt;
  logic             fall;

  assign fall      = en_q & ~line_en;
  assign adv       = active & ~fifo_empty;
  assign first_pix = adv & (cnt == '0);
  assign last_pix  = adv & (cnt == hres - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      en_q <= line_en;
      if (active) begin
        if (adv) begin
          if (last_pix) begin
            active <= 1'b0;
            cnt    <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end else if (fall && (hres != '0)) begin
        active <= 1'b1;
        cnt    <= '0;
      end
    end
  end

  // R3: count never reaches the line length while running
  a_r3_cnt_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < hres));

  // R6: an empty FIFO freezes the line position
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fifo_empty) |=> (active && $stable(cnt)));

  // R7: a falling edge mid-line neither restarts nor ends the line
  a_r7_busy_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last_pix && fall) |=> (active && cnt == $past(cnt) + CNT_W'($past(adv))));

endmodule

// File: rtl/word_slicer.sv
module word_slicer
  import unpack_pkg::*;
#(
  parameter int WORD_W = 128,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              last_pix,
  input  logic [WORD_W-1:0] word,
  output logic              pop,
  output logic [PIX_W-1:0]  pix
);

  localparam int NLANE = lanes_per_word(WORD_W, PIX_W);
  localparam int IDX_W = $clog2(NLANE);

  logic [PIX_W-1:0] lanes [NLANE];
  logic [IDX_W-1:0] idx;
  logic             word_end;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = word[g*PIX_W +: PIX_W];
  end

  assign pix      = lanes[idx];
  assign word_end = (idx == IDX_W'(NLANE - 1));
  assign pop      = adv & (word_end | last_pix);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (pop) begin
      idx <= '0;
    end else if (adv) begin
      idx <= idx + IDX_W'(1);
    end
  end

  // R5: the lane index returns to zero only through a pop
  a_r5_lane_reset_by_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idx) != '0 && idx == '0) |-> $past(pop));

endmodule

// File: rtl/frame_flags.sv
module frame_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic first_pix,
  input  logic last_pix,
  output logic start_now,
  output logic end_now
);

  logic end_pend;
  logic start_pend;

  assign end_now   = last_pix & (end_pend | frame_end);
  assign start_now = first_pix & start_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_pend   <= 1'b0;
      start_pend <= 1'b1;
    end else begin
      if (last_pix)       end_pend <= 1'b0;
      else if (frame_end) end_pend <= 1'b1;

      if (end_now)        start_pend <= 1'b1;
      else if (first_pix) start_pend <= 1'b0;
    end
  end

  // R8: after a frame-end pixel a frame start is pending
  a_r8_start_armed: assert property (@(posedge clk) disable iff (!rst_n)
    end_now |=> start_pend);

endmodule

// File: rtl/line_pixel_unpacker.sv
module line_pixel_unpacker
  import unpack_pkg::*;
#(
  parameter int WORD_W = 128,
  parameter int PIX_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_en,
  input  logic               frame_end,
  input  logic [CNT_W-1:0]   hres,
  input  logic [WORD_W-1:0]  fifo_rdata,
  input  logic               fifo_empty,
  output logic               fifo_pop,
  output logic               pix_valid,
  output logic [PIX_W-1:0]   pix_data,
  output logic               m_tvalid,
  output logic [PIX_W-1:0]   m_tdata,
  output logic [PIX_W/8-1:0] m_tkeep,
  output logic [PIX_W/8-1:0] m_tstrb,
  output logic [USER_W-1:0]  m_tuser,
  output logic               m_tlast
);

  localparam int BYTES = PIX_W / 8;

  logic             active;
  logic             adv;
  logic             first_pix;
  logic             last_pix;
  logic             start_now;
  logic             end_now;
  logic [PIX_W-1:0] pix;

  line_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_en    (line_en),
    .hres       (hres),
    .fifo_empty (fifo_empty),
    .active     (active),
    .adv        (adv),
    .first_pix  (first_pix),
    .last_pix   (last_pix)
  );

  word_slicer #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_slice (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .last_pix (last_pix),
    .word     (fifo_rdata),
    .pop      (fifo_pop),
    .pix      (pix)
  );

  frame_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .first_pix (first_pix),
    .last_pix  (last_pix),
    .start_now (start_now),
    .end_now   (end_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      m_tuser   <= '0;
      m_tlast   <= 1'b0;
    end else begin
      pix_valid <= adv;
      if (adv) pix_data <= pix;
      m_tuser <= adv ? pack_user(start_now, end_now) : '0;
      m_tlast <= end_now;
    end
  end

  assign m_tvalid = pix_valid;
  assign m_tdata  = pix_data;
  assign m_tkeep  = {BYTES{pix_valid}};
  assign m_tstrb  = {BYTES{pix_valid}};

  // R6: never pop an empty FIFO
  a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R9: frame end flag and last marker travel together with a valid beat
  a_r9_last_pairs_user: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> (m_tvalid && m_tuser[3]));

  // R9: two frame-end beats never follow back to back
  a_r9_last_single: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |=> !m_tlast);

  // R10: keep and strobe mark every byte of a valid beat
  a_r10_keep_full: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (&m_tkeep && &m_tstrb));

endmodule

// File: tb/line_pixel_unpacker_test.sv
module line_pixel_unpacker_test;
  localparam int WW = 128;
  localparam int PW = 8;
  localparam int PPW = WW / PW;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          line_en = 1'b0;
  logic          frame_end = 1'b0;
  logic [CW-1:0] hres = '0;
  logic [WW-1:0] fifo_rdata = '0;
  logic          fifo_empty = 1'b1;
  logic          fifo_pop, pix_valid, m_tvalid, m_tlast;
  logic [PW-1:0] pix_data, m_tdata;
  logic [PW/8-1:0] m_tkeep, m_tstrb;
  logic [3:0]    m_tuser;

  line_pixel_unpacker uut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .frame_end(frame_end), .hres(hres),
    .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .pix_valid(pix_valid), .pix_data(pix_data), .m_tvalid(m_tvalid), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tstrb(m_tstrb), .m_tuser(m_tuser), .m_tlast(m_tlast)
  );

  logic [WW-1:0] q[$];
  int  errors = 0, checks = 0, wcount = 0, line_pix = 0;
  bit  stall = 0, run_model = 0, pop_pend = 0;
  bit  m_act = 0, m_le = 0, m_fe = 0, m_vs = 1;
  int  m_cnt = 0, m_idx = 0;
  bit  exp_valid = 0, exp_last = 0, exp_pop = 0;
  logic [PW-1:0] exp_data = '0;
  logic [3:0]    exp_user = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic logic [WW-1:0] word_of(input int w);
    logic [WW-1:0] r;
    for (int k = 0; k < PPW; k++) r[k*PW +: PW] = PW'(w * PPW + k + 7);
    return r;
  endfunction

  // reference: compare, update FIFO model, predict next beat
  always @(negedge clk) begin
    if (run_model) begin
      chk(pix_valid === exp_valid, "R2 R3 R6", "valid", pix_valid, exp_valid);
      if (exp_valid) begin
        line_pix++;
        chk(pix_data === exp_data, "R4 R5", "pixel", pix_data, exp_data);
        chk(m_tuser === exp_user, "R8 R9", "tuser", m_tuser, exp_user);
      end else begin
        chk(m_tuser === 4'h0, "R8 R9", "tuser idle", m_tuser, 0);
      end
      chk(m_tlast === exp_last, "R9", "tlast", m_tlast, exp_last);
      chk(m_tkeep === {(PW/8){exp_valid}} && m_tstrb === {(PW/8){exp_valid}},
          "R10", "keep/strb", {m_tkeep, m_tstrb}, {(PW/4){exp_valid}});
      chk(m_tvalid === pix_valid && m_tdata === pix_data, "R10", "stream mirror",
          {m_tvalid, m_tdata}, {pix_valid, pix_data});
      if (pop_pend) void'(q.pop_front());
      fifo_empty = (q.size() == 0) || stall;
      fifo_rdata = (q.size() != 0) ? q[0] : '0;
      begin
        bit fall, adv, first, last, fe, vs, was_act;
        fall = m_le && !line_en;
        was_act = m_act;
        adv = m_act && !fifo_empty;
        exp_valid = adv; exp_last = 0; exp_user = '0; exp_pop = 0;
        if (adv) begin
          first = (m_cnt == 0);
          last  = (m_cnt == int'(hres) - 1);
          fe = last && (m_fe || frame_end);
          vs = first && m_vs;
          exp_data = q[0][m_idx*PW +: PW];
          exp_user = {fe, 2'b00, vs};
          exp_last = fe;
          exp_pop = (m_idx == PPW - 1) || last;
          m_idx = exp_pop ? 0 : m_idx + 1;
          if (first) m_vs = 0;
          if (fe) m_vs = 1;
          if (last) begin m_fe = 0; m_act = 0; m_cnt = 0; end
          else begin m_cnt++; if (frame_end) m_fe = 1; end
        end else if (frame_end) m_fe = 1;
        if (!was_act && fall && hres != 0) begin m_act = 1; m_cnt = 0; end
        m_le = line_en;
      end
      #1;
      chk(fifo_pop === exp_pop, "R5 R6", "pop", fifo_pop, exp_pop);
      pop_pend = fifo_pop;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) begin q.push_back(word_of(wcount)); wcount++; end
  endtask

  task automatic launch(input int len, input int high);
    line_pix = 0;
    hres = CW'(len);
    line_en = 1'b1;
    tick(high);
    line_en = 1'b0;
  endtask

  task automatic settle();
    tick(2);
    while (m_act) tick(1);
    tick(3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    chk(!pix_valid && !m_tvalid && !m_tlast && m_tuser == 0 && m_tkeep == 0
        && m_tstrb == 0 && !fifo_pop, "R1", "reset outputs",
        {pix_valid, m_tvalid, m_tlast, m_tuser, m_tkeep, fifo_pop}, 0);
    rst_n = 1'b1;
    run_model = 1;
    tick(2);

    // two full words, frame start after reset (R2 R4 R8)
    fill(2); launch(32, 3); settle();
    chk(line_pix == 32, "R3", "line length 32", line_pix, 32);

    // partial second word dropped, frame end mid-line (R5 R9)
    fill(2); launch(20, 2); tick(5);
    frame_end = 1'b1; tick(1); frame_end = 1'b0;
    settle();
    chk(line_pix == 20, "R3", "line length 20", line_pix, 20);
    chk(q.size() == 0, "R5", "words consumed", q.size(), 0);

    // stall mid-line (R6)
    fill(1); launch(16, 2); tick(6);
    stall = 1'b1; tick(2);
    chk(pix_valid == 1'b0, "R6", "valid low on empty", pix_valid, 0);
    tick(2); stall = 1'b0;
    settle();
    chk(line_pix == 16, "R6", "length kept across stall", line_pix, 16);

    // busy falling edge ignored, frame end on last pixel edge (R7 R9)
    fill(3); launch(40, 2); tick(8);
    line_en = 1'b1; tick(2); line_en = 1'b0;
    while (!(m_act && m_cnt == 39)) tick(1);
    frame_end = 1'b1; tick(1); frame_end = 1'b0;
    settle(); tick(6);
    chk(line_pix == 40, "R7", "no restart from busy edge", line_pix, 40);

    // one-pixel line with start and end flags together (R8 R9)
    fill(1); frame_end = 1'b1; launch(1, 2); frame_end = 1'b0; settle();
    chk(line_pix == 1, "R3", "line length 1", line_pix, 1);
    fill(1); launch(1, 2); settle();
    chk(line_pix == 1, "R8", "start-only line", line_pix, 1);

    // zero length starts nothing (R3)
    fill(1); launch(0, 2); tick(8);
    chk(line_pix == 0, "R3", "zero length", line_pix, 0);
    chk(q.size() == 1, "R3", "zero length pops nothing", q.size(), 1);

    run_model = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule